// File: doc/BRIEF.md
# Power domain power-up sequencer

This block brings a single gated power domain up in a fixed, safe order. A one-cycle start request first puts the domain into reset, with its clock off and its isolation clamp engaged. It then asks the power switch to turn on, enables the domain clock, waits a settle time, releases the isolation clamp, waits a second settle time, and finally takes the domain out of reset. The power switch takes a one-cycle toggle command and reports its state on a status line. The clock gate and the clamp each answer their enable with an acknowledge line.

Each handshake is guarded by a timeout. When a step times out, the sequencer undoes the steps it has already taken, in reverse order, and reports which step failed. The domain is left in reset after a failure. Both settle times are counted in clock cycles, derived from the clock frequency in MHz and the settle time in microseconds.

Top module: `pdseq_top`

## Requirements
- R1: After reset the domain reset output is high and every other output is low.
- R2: A start accepted in idle drives the domain reset high, the clock enable low and the clamp release low on the next cycle. If the power status is low, exactly one single-cycle toggle is then issued, and the domain reset is high whenever a toggle is issued.
- R3: If the power status is already high when the power step is checked, no toggle is issued and the sequence moves on to the clock step.
- R4: The clock enable rises only while the power status is high.
- R5: The clamp release rises exactly SETTLE = CLK_MHZ*SETTLE_US cycles after the clock edge that first samples the clock acknowledge high.
- R6: The domain reset falls exactly SETTLE cycles after the clock edge that first samples the clamp acknowledge high. Done pulses in that same cycle. After success the clock enable is high, the clamp release is high and the domain reset is low.
- R7: The sequencer waits at most ACK_TIMEOUT cycles for power status, clock acknowledge or clamp acknowledge. If the wait runs out, that step has failed.
- R8: On a clamp failure, the clamp release drops at once. The clock enable drops one cycle later. One cycle after that, a power-off toggle is issued if the domain is powered, together with the error pulse. The failure code is 3.
- R9: On a clock failure, the clock enable drops at once and the clamp is never released. One cycle later, a power-off toggle is issued if the domain is powered, together with the error pulse. The failure code is 2.
- R10: On a power failure, the error pulse comes ACK_TIMEOUT cycles after the toggle, with no further toggle. The failure code is 1.
- R11: Done and error are single-cycle pulses. The failure code is nonzero only while the error pulse is high. The domain reset stays high after an error.
- R12: A start request while busy is ignored, and the running sequence completes with exactly one done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Single-cycle power-up request |
| pwr_stat_i | input | 1 | Power switch state, 1 = domain powered |
| clk_ack_i | input | 1 | Clock gate acknowledge |
| clamp_ack_i | input | 1 | Clamp release acknowledge |
| pwr_toggle_o | output | 1 | Single-cycle command to flip the power switch |
| dom_rst_o | output | 1 | Domain reset, 1 = held in reset |
| clk_en_o | output | 1 | Domain clock enable |
| clamp_rel_o | output | 1 | Isolation clamp release, 1 = released |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Single-cycle success pulse |
| err_o | output | 1 | Single-cycle failure pulse |
| err_step_o | output | 2 | Failed step: 1 power, 2 clock, 3 clamp; 0 outside the error pulse |

## Verification
On every cycle the assertions check the ordering rules. A toggle is only issued under reset. The clock enable only rises with power present. The clamp is only released with the clock running, and reset is only released with clamp and clock both up and done. They also check the reverse unwinding right after each failure event, and that the pulses are single-cycle. The exact settle and timeout cycle counts can only be shown by the bench's timed scenarios. So can the final state of the domain after success or failure, the skipped toggle for a domain that is already powered, and the ignored start while busy.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_PWR_CHK, S_PWR_WAIT, S_CLK_WAIT, S_SETTLE1,
    S_CLAMP_WAIT, S_SETTLE2, S_FIN, S_UNW_CLK, S_UNW_PWR, S_FAIL
  } seq_state_e;

  typedef enum logic [1:0] {
    STEP_NONE  = 2'd0,
    STEP_PWR   = 2'd1,
    STEP_CLK   = 2'd2,
    STEP_CLAMP = 2'd3
  } step_e;

  // settle delay in cycles from clock frequency and time
  function automatic int unsigned settle_cycles(int unsigned mhz, int unsigned us);
    return mhz * us;
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pdseq_timer.sv
module pdseq_timer #(
  parameter int unsigned SETTLE_CYC = 1,
  parameter int unsigned ACK_TMO    = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic settle_hit_o,
  output logic tmo_hit_o
);
  import pdseq_pkg::*;

  localparam int unsigned TOP = max_u(max_u(SETTLE_CYC, ACK_TMO), 2);
  localparam int          W   = $clog2(TOP);
  localparam logic [W-1:0] LAST   = W'(TOP - 1);
  localparam logic [W-1:0] S_LAST = W'(SETTLE_CYC - 1);
  localparam logic [W-1:0] T_LAST = W'(ACK_TMO - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign settle_hit_o = (cnt_q == S_LAST);
  assign tmo_hit_o    = (cnt_q == T_LAST);

endmodule

// File: rtl/pdseq_fsm.sv
module pdseq_fsm (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              pwr_stat_i,
  input  logic              clk_ack_i,
  input  logic              clamp_ack_i,
  input  logic              settle_hit_i,
  input  logic              tmo_hit_i,
  output logic              timer_clr_o,
  output logic              pwr_toggle_o,
  output logic              dom_rst_o,
  output logic              clk_en_o,
  output logic              clamp_rel_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output pdseq_pkg::step_e  err_step_o,
  output logic              ev_pwr_fail_o,
  output logic              ev_clk_fail_o,
  output logic              ev_clamp_fail_o
);
  import pdseq_pkg::*;

  seq_state_e st_q, st_d;
  step_e      fail_q, fail_d;
  logic       rst_q, rst_d, tog_q, tog_d, cen_q, cen_d, clp_q, clp_d;

  always_comb begin
    st_d = st_q;  fail_d = fail_q;
    rst_d = rst_q; tog_d = 1'b0; cen_d = cen_q; clp_d = clp_q;
    ev_pwr_fail_o = 1'b0; ev_clk_fail_o = 1'b0; ev_clamp_fail_o = 1'b0;
    unique case (st_q)
      S_IDLE: if (start_i) begin
        st_d = S_PWR_CHK; rst_d = 1'b1; cen_d = 1'b0; clp_d = 1'b0; fail_d = STEP_NONE;
      end
      S_PWR_CHK: if (pwr_stat_i) begin
        st_d = S_CLK_WAIT; cen_d = 1'b1;
      end else begin
        st_d = S_PWR_WAIT; tog_d = 1'b1;
      end
      S_PWR_WAIT: if (pwr_stat_i) begin
        st_d = S_CLK_WAIT; cen_d = 1'b1;
      end else if (tmo_hit_i) begin
        st_d = S_FAIL; fail_d = STEP_PWR; ev_pwr_fail_o = 1'b1;
      end
      S_CLK_WAIT: if (clk_ack_i) begin
        st_d = S_SETTLE1;
      end else if (tmo_hit_i) begin
        st_d = S_UNW_PWR; cen_d = 1'b0; fail_d = STEP_CLK; ev_clk_fail_o = 1'b1;
      end
      S_SETTLE1: if (settle_hit_i) begin
        st_d = S_CLAMP_WAIT; clp_d = 1'b1;
      end
      S_CLAMP_WAIT: if (clamp_ack_i) begin
        st_d = S_SETTLE2;
      end else if (tmo_hit_i) begin
        st_d = S_UNW_CLK; clp_d = 1'b0; fail_d = STEP_CLAMP; ev_clamp_fail_o = 1'b1;
      end
      S_SETTLE2: if (settle_hit_i) begin
        st_d = S_FIN; rst_d = 1'b0;
      end
      S_FIN:     st_d = S_IDLE;
      S_UNW_CLK: begin st_d = S_UNW_PWR; cen_d = 1'b0; end
      S_UNW_PWR: begin st_d = S_FAIL; tog_d = pwr_stat_i; end
      S_FAIL:    st_d = S_IDLE;
      default:   st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; fail_q <= STEP_NONE;
      rst_q <= 1'b1; tog_q <= 1'b0; cen_q <= 1'b0; clp_q <= 1'b0;
    end else begin
      st_q <= st_d; fail_q <= fail_d;
      rst_q <= rst_d; tog_q <= tog_d; cen_q <= cen_d; clp_q <= clp_d;
    end
  end

  assign timer_clr_o  = (st_d != st_q);
  assign pwr_toggle_o = tog_q;
  assign dom_rst_o    = rst_q;
  assign clk_en_o     = cen_q;
  assign clamp_rel_o  = clp_q;
  assign busy_o       = (st_q != S_IDLE);
  assign done_o       = (st_q == S_FIN);
  assign err_o        = (st_q == S_FAIL);
  assign err_step_o   = (st_q == S_FAIL) ? fail_q : STEP_NONE;

endmodule

// File: rtl/pdseq_top.sv
module pdseq_top #(
  parameter int unsigned CLK_MHZ     = 125,
  parameter int unsigned SETTLE_US   = 10,
  parameter int unsigned ACK_TIMEOUT = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       pwr_stat_i,
  input  logic       clk_ack_i,
  input  logic       clamp_ack_i,
  output logic       pwr_toggle_o,
  output logic       dom_rst_o,
  output logic       clk_en_o,
  output logic       clamp_rel_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o,
  output logic [1:0] err_step_o
);
  import pdseq_pkg::*;

  localparam int unsigned SETTLE_CYC = settle_cycles(CLK_MHZ, SETTLE_US);

  logic  timer_clr, settle_hit, tmo_hit;
  logic  ev_pwr_fail, ev_clk_fail, ev_clamp_fail;
  step_e fail_step;

  pdseq_timer #(.SETTLE_CYC(SETTLE_CYC), .ACK_TMO(ACK_TIMEOUT)) i_timer (
    .clk(clk), .rst_n(rst_n), .clr_i(timer_clr),
    .settle_hit_o(settle_hit), .tmo_hit_o(tmo_hit)
  );

  pdseq_fsm i_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .pwr_stat_i(pwr_stat_i), .clk_ack_i(clk_ack_i), .clamp_ack_i(clamp_ack_i),
    .settle_hit_i(settle_hit), .tmo_hit_i(tmo_hit), .timer_clr_o(timer_clr),
    .pwr_toggle_o(pwr_toggle_o), .dom_rst_o(dom_rst_o), .clk_en_o(clk_en_o),
    .clamp_rel_o(clamp_rel_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .err_step_o(fail_step), .ev_pwr_fail_o(ev_pwr_fail),
    .ev_clk_fail_o(ev_clk_fail), .ev_clamp_fail_o(ev_clamp_fail)
  );

  assign err_step_o = fail_step;

endmodule

// File: rtl/pdseq_chk.sv
module pdseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_stat_i,
  input logic       pwr_toggle_o,
  input logic       dom_rst_o,
  input logic       clk_en_o,
  input logic       clamp_rel_o,
  input logic       done_o,
  input logic       err_o,
  input logic [1:0] err_step_o,
  input logic       ev_pwr_fail,
  input logic       ev_clk_fail,
  input logic       ev_clamp_fail
);

  // R2: a toggle is only issued while the domain is held in reset
  a_r2_toggle_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_toggle_o |-> dom_rst_o);

  a_r4_clk_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en_o) |-> pwr_stat_i);

  // R5: clamp released only with the clock running
  a_r5_clamp_after_clk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clamp_rel_o) |-> clk_en_o);

  a_r6_reset_release_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dom_rst_o) |-> (clamp_rel_o && clk_en_o && done_o));

  a_r8_clamp_unwind: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clamp_fail |=> (!clamp_rel_o && clk_en_o) ##1 (!clk_en_o && !err_o) ##1 err_o);

  a_r9_clk_unwind: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clk_fail |=> (!clk_en_o && !clamp_rel_o && !err_o) ##1 err_o);

  a_r10_pwr_fail: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pwr_fail |=> (err_o && !pwr_toggle_o && !clk_en_o));

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r11_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);

  a_r11_code_with_err: assert property (@(posedge clk) disable iff (!rst_n)
    (err_step_o != 2'd0) |-> err_o);

  a_r11_err_holds_reset: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (dom_rst_o && !done_o));

endmodule

bind pdseq_top pdseq_chk i_pdseq_chk (
  .clk(clk), .rst_n(rst_n), .pwr_stat_i(pwr_stat_i), .pwr_toggle_o(pwr_toggle_o),
  .dom_rst_o(dom_rst_o), .clk_en_o(clk_en_o), .clamp_rel_o(clamp_rel_o),
  .done_o(done_o), .err_o(err_o), .err_step_o(err_step_o),
  .ev_pwr_fail(ev_pwr_fail), .ev_clk_fail(ev_clk_fail), .ev_clamp_fail(ev_clamp_fail)
);

// File: tb/test_pdseq_top.sv
`timescale 1ns/1ps
module test_pdseq_top;
  localparam int MHZ = 3;
  localparam int US  = 2;
  localparam int TMO = 20;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic pwr_stat_i = 1'b0, clk_ack_i = 1'b0, clamp_ack_i = 1'b0;
  logic pwr_toggle_o, dom_rst_o, clk_en_o, clamp_rel_o, busy_o, done_o, err_o;
  logic [1:0] err_step_o;

  pdseq_top #(.CLK_MHZ(MHZ), .SETTLE_US(US), .ACK_TIMEOUT(TMO)) i_pdseq_top (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pwr_stat_i(pwr_stat_i),
    .clk_ack_i(clk_ack_i), .clamp_ack_i(clamp_ack_i), .pwr_toggle_o(pwr_toggle_o),
    .dom_rst_o(dom_rst_o), .clk_en_o(clk_en_o), .clamp_rel_o(clamp_rel_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .err_step_o(err_step_o)
  );

  always #4 clk = ~clk;   // 125 MHz

  int nvec = 0, nfail = 0, wd = 0;

  // environment knobs
  bit e_pwr_ok, e_clk_ok, e_clamp_ok, force_en, force_val;
  int e_pwr_lat, e_clk_lat, e_clamp_lat;
  int ccnt = 0, mcnt = 0, pend = 0;

  always @(negedge clk) begin
    if (force_en) begin
      pwr_stat_i <= force_val; pend <= 0;
    end else if (pwr_toggle_o && (pwr_stat_i || e_pwr_ok)) begin
      pend <= e_pwr_lat + 1;
    end else if (pend == 1) begin
      pwr_stat_i <= ~pwr_stat_i; pend <= 0;
    end else if (pend > 1) pend <= pend - 1;
    if (clk_en_o && e_clk_ok) begin
      if (ccnt >= e_clk_lat) clk_ack_i <= 1'b1;
      ccnt <= ccnt + 1;
    end else begin ccnt <= 0; clk_ack_i <= 1'b0; end
    if (clamp_rel_o && e_clamp_ok) begin
      if (mcnt >= e_clamp_lat) clamp_ack_i <= 1'b1;
      mcnt <= mcnt + 1;
    end else begin mcnt <= 0; clamp_ack_i <= 1'b0; end
  end

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 150000) begin
      $display("FAIL watchdog expired act=%0d exp=<150000", wd);
      $display("== %0d vectors applied, %0d miscompares ==", nvec + 1, nfail + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // settle reference restated as repeated addition
  function automatic int ref_settle(int mhz, int us);
    int s = 0;
    for (int i = 0; i < us; i++) s += mhz;
    return s;
  endfunction

  function automatic int ref_outcome(bit pre, bit pok, bit cok, bit mok);
    if (!pre && !pok) return 1;
    if (!cok) return 2;
    if (!mok) return 3;
    return 0;
  endfunction

  int t_cack, t_mack, t_clk_rise, t_clk_fall, t_clp_rise, t_clp_fall, t_rst_fall;
  int t_tog_first, t_tog_last, t_done, t_err, n_done, n_err, n_tog, code;
  bit bad_code, k1_ok;

  task automatic run_seq(input bit poke);
    int k; int tail; bit p_clk, p_clp, p_rst;
    t_cack = -1; t_mack = -1; t_clk_rise = -1; t_clk_fall = -1; t_clp_rise = -1;
    t_clp_fall = -1; t_rst_fall = -1; t_tog_first = -1; t_tog_last = -1;
    t_done = -1; t_err = -1; n_done = 0; n_err = 0; n_tog = 0; code = 0; bad_code = 0;
    @(posedge clk); #1; start_i = 1'b1;
    @(posedge clk); #1; start_i = 1'b0; k = 1;
    k1_ok = dom_rst_o && !clk_en_o && !clamp_rel_o && busy_o;
    p_clk = clk_en_o; p_clp = clamp_rel_o; p_rst = dom_rst_o;
    tail = -1;
    while (k < 2000 && tail != 0) begin
      @(posedge clk); #1; k++;
      if (poke && k == 6) start_i = 1'b1;
      if (poke && k == 7) start_i = 1'b0;
      if (pwr_toggle_o) begin n_tog++; if (t_tog_first < 0) t_tog_first = k; t_tog_last = k; end
      if (clk_ack_i && t_cack < 0) t_cack = k;
      if (clamp_ack_i && t_mack < 0) t_mack = k;
      if (clk_en_o && !p_clk) t_clk_rise = k;
      if (!clk_en_o && p_clk) t_clk_fall = k;
      if (clamp_rel_o && !p_clp) t_clp_rise = k;
      if (!clamp_rel_o && p_clp) t_clp_fall = k;
      if (!dom_rst_o && p_rst) t_rst_fall = k;
      if (done_o) begin n_done++; t_done = k; end
      if (err_o) begin n_err++; t_err = k; code = err_step_o; end
      else if (err_step_o != 2'd0) bad_code = 1'b1;
      p_clk = clk_en_o; p_clp = clamp_rel_o; p_rst = dom_rst_o;
      if (tail > 0) tail--;
      else if (tail < 0 && (done_o || err_o)) tail = 12;
    end
  endtask

  task automatic scenario(input bit pre, input bit pok, input int plat, input bit cok,
                          input int clat, input bit mok, input int mlat, input bit poke);
    int exp; int s;
    s = ref_settle(MHZ, US);
    exp = ref_outcome(pre, pok, cok, mok);
    e_pwr_ok = pok; e_pwr_lat = plat; e_clk_ok = cok; e_clk_lat = clat;
    e_clamp_ok = mok; e_clamp_lat = mlat;
    @(posedge clk); #1; force_en = 1'b1; force_val = pre;
    @(posedge clk); #1; @(posedge clk); #1; force_en = 1'b0;
    run_seq(poke);
    chk(k1_ok, "R2 entry state after start", k1_ok, 1);
    chk(!bad_code, "R11 code outside error pulse", bad_code, 0);
    if (exp == 0) begin
      chk(n_done == 1 && n_err == 0, "R11 single done pulse", n_done, 1);
      chk(t_clp_rise - t_cack == s, "R5 settle before clamp release", t_clp_rise - t_cack, s);
      chk(t_rst_fall - t_mack == s, "R6 settle before reset release", t_rst_fall - t_mack, s);
      chk(t_done == t_rst_fall, "R6 done with reset release", t_done, t_rst_fall);
      chk(clk_en_o && clamp_rel_o && !dom_rst_o && pwr_stat_i, "R6 final state",
          {clk_en_o, clamp_rel_o, dom_rst_o, pwr_stat_i}, 4'b1101);
      if (pre) chk(n_tog == 0, "R3 no toggle when powered", n_tog, 0);
      else begin
        chk(n_tog == 1, "R2 single toggle", n_tog, 1);
        chk(t_clk_rise > t_tog_first, "R4 clock after power", t_clk_rise, t_tog_first + 1);
      end
      if (poke) chk(n_done == 1 && !busy_o, "R12 start while busy ignored", n_done, 1);
    end else begin
      chk(n_err == 1 && n_done == 0 && code == exp, "R11 error code", code, exp);
      chk(dom_rst_o && !clk_en_o && !clamp_rel_o && !pwr_stat_i, "R11 domain left off",
          {dom_rst_o, clk_en_o, clamp_rel_o, pwr_stat_i}, 4'b1000);
      if (exp == 1) begin
        chk(t_err - t_tog_first == TMO, "R7 power timeout", t_err - t_tog_first, TMO);
        chk(n_tog == 1 && t_clk_rise < 0, "R10 no unwind toggle", n_tog, 1);
      end else if (exp == 2) begin
        chk(t_clk_fall - t_clk_rise == TMO, "R7 clock timeout", t_clk_fall - t_clk_rise, TMO);
        chk(t_clp_rise < 0 && t_tog_last == t_clk_fall + 1 && t_err == t_tog_last,
            "R9 clock unwind", t_tog_last, t_clk_fall + 1);
      end else begin
        chk(t_clp_fall - t_clp_rise == TMO, "R7 clamp timeout", t_clp_fall - t_clp_rise, TMO);
        chk(t_clk_fall == t_clp_fall + 1 && t_tog_last == t_clp_fall + 2 && t_err == t_tog_last,
            "R8 clamp unwind order", t_tog_last, t_clp_fall + 2);
      end
    end
  endtask

  initial begin
    int unsigned r;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(dom_rst_o === 1'b1, "R1 reset holds domain reset", dom_rst_o, 1);
    chk({pwr_toggle_o, clk_en_o, clamp_rel_o, busy_o, done_o, err_o, err_step_o} === 8'd0,
        "R1 reset outputs low", {pwr_toggle_o, clk_en_o, clamp_rel_o}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk(dom_rst_o && !busy_o && !clk_en_o, "R1 idle after reset", busy_o, 0);

    scenario(0, 1, 2, 1, 1, 1, 3, 0);   // plain success
    scenario(1, 1, 0, 1, 0, 1, 0, 0);   // already powered
    scenario(0, 1, 0, 0, 0, 1, 0, 0);   // clock failure
    scenario(0, 1, 1, 1, 2, 0, 0, 0);   // clamp failure
    scenario(0, 0, 0, 1, 0, 1, 0, 0);   // power failure
    scenario(0, 1, 3, 1, 4, 1, 5, 1);   // start while busy
    scenario(1, 1, 0, 0, 0, 1, 0, 0);   // clock failure, pre-powered
    scenario(0, 1, 8, 1, 8, 1, 8, 0);   // long latencies

    r = $urandom(32'h1234_5eed);
    for (int i = 0; i < 24; i++) begin
      bit pre, pok, cok, mok;
      r = $urandom; pre = (r % 3) == 0;
      r = $urandom; pok = (r % 6) != 0;
      r = $urandom; cok = (r % 5) != 0;
      r = $urandom; mok = (r % 5) != 0;
      scenario(pre, pok, int'($urandom % 9), cok, int'($urandom % 9),
               mok, int'($urandom % 9), (i % 4) == 1 && ref_outcome(pre, pok, cok, mok) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule